// File: doc/BRIEF.md
# Host Power State and Self-Clocking Monitor

This block watches three host status lines: supply good, lid shut (low when closed) and host asleep (low when suspended). It also watches a small group of general active-low interrupt lines. Every line is synchronised and debounced. From the filtered power, lid and suspend lines the block decodes a three-bit host state code. That code selects which reporting tasks, keyboard and pointer, may run.

Every edge of the supply, lid and general lines raises a one-cycle interrupt pulse. Each change of host state becomes an alert item on a valid/ready output stream, which the packet layer queues.

The block also chooses its own clock level. Stop is the resting level. Wait keeps a timer alive for LED blinking or a PWM channel. Run is held while an alert is pending, a host transfer is in progress, an interrupt pulse is out, a general line is held active, or software forces it. The level drives an oscillator enable and a clock-run request.

Top module: `pwr_state_monitor`

## Requirements
- R1: While filtered supply-good is low the host state code is 3'b000 (Critical), whatever the lid and suspend lines show.
- R2: Supply-good high, lid line high and suspend line high give code 3'b001 (Active).
- R3: Supply-good high, lid line high and suspend line low give code 3'b010 (Host Suspend).
- R4: Supply-good high and lid line low give code 3'b011 (Lid Closed), whatever the suspend line shows.
- R5: A line change takes effect only after it has been stable for DEB_CYCLES clocks (default 4) past the two-flop synchroniser. A shorter pulse produces no interrupt, no alert and no level change.
- R6: Each filtered edge, rising or falling, gives a one-cycle pulse on `irq_o`. Bit 0 is supply-good, bit 1 is the lid line, and bit 2+k is general line k. The suspend line raises no interrupt.
- R7: Alert stream: when the host state differs from the last accepted code, `evt_valid_o` rises carrying the current code. Valid and code stay stable until `evt_ready_i` is high at a clock edge. After acceptance the block raises a new alert only if the state now differs from the accepted code. States passed through while an alert waits are not reported.
- R8: `kbd_en_o` is high in Active and Host Suspend and `ptr_en_o` only in Active. Override bit 0 clears the keyboard enable and override bit 1 clears the pointer enable.
- R9: Level codes are 2'b00 Stop, 2'b01 Wait and 2'b10 Run. Stop is the level whenever no cause applies. `osc_en_o` is high unless the level is Stop, and `clk_run_req_o` is high only in Run.
- R10: Wait is the level when LED blinking or any PWM channel is active and no Run cause applies.
- R11: Run is the level one clock after any of these: a host transfer, a pending alert, an interrupt pulse, a general line held low, or override bit 2.
- R12: Under reset the state code is Critical. No alert is valid, no interrupt is raised, both task enables are low and the level is Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supply good, asynchronous |
| lid_n_i | input | 1 | Lid shut when low, asynchronous |
| host_susp_n_i | input | 1 | Host asleep when low, asynchronous |
| gint_n_i | input | GINT_W | General active-low interrupt lines |
| sw_ovr_i | input | 3 | Software overrides: bit0 keyboard off, bit1 pointer off, bit2 force Run |
| led_blink_i | input | 1 | LED blinking active |
| pwm_on_i | input | PWM_CH | PWM channel active flags |
| host_xfer_i | input | 1 | Host transaction in progress |
| host_state_o | output | 3 | Current host state code |
| evt_valid_o | output | 1 | Alert item valid |
| evt_ready_i | input | 1 | Alert item accepted |
| evt_code_o | output | 3 | State code carried by the alert |
| irq_o | output | GINT_W+2 | Edge interrupt pulses |
| kbd_en_o | output | 1 | Keyboard reporting enable |
| ptr_en_o | output | 1 | Pointer reporting enable |
| level_o | output | 2 | Own clock level |
| osc_en_o | output | 1 | Oscillator enable |
| clk_run_req_o | output | 1 | Full-speed clock request |

## Verification
The decode is walked through all four host states, and each is left by a different line. This separates supply-good dominance from lid dominance and shows that the suspend line counts only when the lid is open. A two-cycle glitch on a general line is set against a held change of the same line, which shows that the filter rejects short pulses and passes real ones. Back-pressure on the alert stream across two state changes shows that the payload holds and that the newer state is re-raised. Level causes are added one at a time and then stacked, which shows the Stop, Wait and Run priority.

// File: rtl/psm_pkg.sv
package psm_pkg;
  typedef enum logic [2:0] {
    HS_CRIT   = 3'b000,
    HS_ACTIVE = 3'b001,
    HS_SUSP   = 3'b010,
    HS_LID    = 3'b011
  } host_st_e;

  typedef enum logic [1:0] {
    LV_STOP = 2'b00,
    LV_WAIT = 2'b01,
    LV_RUN  = 2'b10
  } level_e;

  localparam int OVR_W       = 3;
  localparam int OVR_KBD_OFF = 0;
  localparam int OVR_PTR_OFF = 1;
  localparam int OVR_RUN     = 2;

  function automatic host_st_e decode_host(input logic pg, input logic lid_n,
                                           input logic susp_n);
    if (!pg)          return HS_CRIT;
    else if (!lid_n)  return HS_LID;
    else if (!susp_n) return HS_SUSP;
    else              return HS_ACTIVE;
  endfunction
endpackage

// File: rtl/psm_sync_filter.sv
module psm_sync_filter #(
  parameter int   DEB_CYCLES = 4,
  parameter logic RST_VAL    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic          s1_q, s2_q, filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= RST_VAL;
      s2_q   <= RST_VAL;
      filt_q <= RST_VAL;
      cnt_q  <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q != filt_q) begin
        if (cnt_q == CW'(DEB_CYCLES - 1)) begin
          filt_q <= s2_q;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/psm_host_fsm.sv
module psm_host_fsm
  import psm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg_i,
  input  logic             lid_n_i,
  input  logic             susp_n_i,
  input  logic [OVR_W-1:0] ovr_i,
  input  logic             evt_ready_i,
  output logic [2:0]       state_o,
  output logic             evt_valid_o,
  output logic [2:0]       evt_code_o,
  output logic             kbd_en_o,
  output logic             ptr_en_o
);
  host_st_e state_q, rep_q, code_q;
  logic     pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_CRIT;
      rep_q   <= HS_CRIT;
      code_q  <= HS_CRIT;
      pend_q  <= 1'b0;
    end else begin
      state_q <= decode_host(pg_i, lid_n_i, susp_n_i);
      if (pend_q) begin
        if (evt_ready_i) begin
          pend_q <= 1'b0;
          rep_q  <= code_q;
        end
      end else if (state_q != rep_q) begin
        pend_q <= 1'b1;
        code_q <= state_q;
      end
    end
  end

  assign state_o     = state_q;
  assign evt_valid_o = pend_q;
  assign evt_code_o  = code_q;
  assign kbd_en_o    = ((state_q == HS_ACTIVE) || (state_q == HS_SUSP)) && !ovr_i[OVR_KBD_OFF];
  assign ptr_en_o    = (state_q == HS_ACTIVE) && !ovr_i[OVR_PTR_OFF];
endmodule

// File: rtl/psm_level_ctl.sv
module psm_level_ctl
  import psm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_cause_i,
  input  logic       wait_cause_i,
  output logic [1:0] level_o,
  output logic       osc_en_o,
  output logic       run_req_o
);
  level_e level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            level_q <= LV_STOP;
    else if (run_cause_i)  level_q <= LV_RUN;
    else if (wait_cause_i) level_q <= LV_WAIT;
    else                   level_q <= LV_STOP;
  end

  assign level_o   = level_q;
  assign osc_en_o  = (level_q != LV_STOP);
  assign run_req_o = (level_q == LV_RUN);
endmodule

// File: rtl/pwr_state_monitor.sv
module pwr_state_monitor
  import psm_pkg::*;
#(
  parameter int GINT_W     = 2,
  parameter int PWM_CH     = 2,
  parameter int DEB_CYCLES = 4,
  localparam int IRQ_W     = GINT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good_i,
  input  logic              lid_n_i,
  input  logic              host_susp_n_i,
  input  logic [GINT_W-1:0] gint_n_i,
  input  logic [OVR_W-1:0]  sw_ovr_i,
  input  logic              led_blink_i,
  input  logic [PWM_CH-1:0] pwm_on_i,
  input  logic              host_xfer_i,
  output logic [2:0]        host_state_o,
  output logic              evt_valid_o,
  input  logic              evt_ready_i,
  output logic [2:0]        evt_code_o,
  output logic [IRQ_W-1:0]  irq_o,
  output logic              kbd_en_o,
  output logic              ptr_en_o,
  output logic [1:0]        level_o,
  output logic              osc_en_o,
  output logic              clk_run_req_o
);
  localparam int NLINES = GINT_W + 3;

  logic [NLINES-1:0] raw_w, filt_w;
  logic [IRQ_W-1:0]  irq_src_w, irq_src_d_q, irq_q;

  assign raw_w = {gint_n_i, host_susp_n_i, lid_n_i, pwr_good_i};

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    psm_sync_filter #(
      .DEB_CYCLES(DEB_CYCLES),
      .RST_VAL   ((i == 0) ? 1'b0 : 1'b1)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw_w[i]),
      .filt_o(filt_w[i])
    );
  end

  assign irq_src_w = {filt_w[NLINES-1:3], filt_w[1], filt_w[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_src_d_q <= {{GINT_W{1'b1}}, 1'b1, 1'b0};
      irq_q       <= '0;
    end else begin
      irq_src_d_q <= irq_src_w;
      irq_q       <= irq_src_w ^ irq_src_d_q;
    end
  end

  assign irq_o = irq_q;

  psm_host_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pg_i       (filt_w[0]),
    .lid_n_i    (filt_w[1]),
    .susp_n_i   (filt_w[2]),
    .ovr_i      (sw_ovr_i),
    .evt_ready_i(evt_ready_i),
    .state_o    (host_state_o),
    .evt_valid_o(evt_valid_o),
    .evt_code_o (evt_code_o),
    .kbd_en_o   (kbd_en_o),
    .ptr_en_o   (ptr_en_o)
  );

  logic run_cause_w, wait_cause_w;
  assign run_cause_w  = host_xfer_i | evt_valid_o | (|irq_q) |
                        ~(&filt_w[NLINES-1:3]) | sw_ovr_i[OVR_RUN];
  assign wait_cause_w = led_blink_i | (|pwm_on_i);

  psm_level_ctl u_lvl (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_cause_i (run_cause_w),
    .wait_cause_i(wait_cause_w),
    .level_o     (level_o),
    .osc_en_o    (osc_en_o),
    .run_req_o   (clk_run_req_o)
  );
endmodule

// File: rtl/pwr_state_monitor_chk.sv
module pwr_state_monitor_chk #(
  parameter int IRQ_W  = 4,
  parameter int NLINES = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] filt,
  input logic [2:0]        host_state_o,
  input logic              evt_valid_o,
  input logic              evt_ready_i,
  input logic [2:0]        evt_code_o,
  input logic [IRQ_W-1:0]  irq_o,
  input logic              ptr_en_o,
  input logic              host_xfer_i,
  input logic [1:0]        level_o
);
  p_crit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !filt[0] |=> (host_state_o == 3'b000));

  p_lid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (filt[0] && !filt[1]) |=> (host_state_o == 3'b011));

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != '0) |=> ((irq_o & $past(irq_o)) == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o && !evt_ready_i) |=> (evt_valid_o && $stable(evt_code_o)));

  p_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_state_o != 3'b001) |-> !ptr_en_o);

  p_xfer_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_xfer_i |=> (level_o == 2'b10));
endmodule

bind pwr_state_monitor pwr_state_monitor_chk #(.IRQ_W(IRQ_W), .NLINES(NLINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .filt        (filt_w),
  .host_state_o(host_state_o),
  .evt_valid_o (evt_valid_o),
  .evt_ready_i (evt_ready_i),
  .evt_code_o  (evt_code_o),
  .irq_o       (irq_o),
  .ptr_en_o    (ptr_en_o),
  .host_xfer_i (host_xfer_i),
  .level_o     (level_o)
);

// File: tb/pwr_state_monitor_bench.sv
module pwr_state_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GINT_W = 2;
  localparam int PWM_CH = 2;
  localparam int IRQ_W  = GINT_W + 2;
  localparam int SETTLE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b1, lid_n = 1'b1, susp_n = 1'b1;
  logic [GINT_W-1:0] gint_n = '1;
  logic [2:0] ovr = '0;
  logic blink = 1'b0;
  logic [PWM_CH-1:0] pwm = '0;
  logic xfer = 1'b0;
  logic evt_ready = 1'b1;
  logic [2:0] host_state, evt_code;
  logic evt_valid, kbd_en, ptr_en, osc_en, run_req;
  logic [IRQ_W-1:0] irq;
  logic [1:0] level;

  int checks = 0, fails = 0;
  logic [2:0] exp_evt_q[$];
  int exp_irq_q[$];
  logic [2:0] last_exp;
  logic mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_monitor #(.GINT_W(GINT_W), .PWM_CH(PWM_CH), .DEB_CYCLES(4)) u_pwr_state_monitor (
    .clk(clk), .rst_n(rst_n), .pwr_good_i(pg), .lid_n_i(lid_n), .host_susp_n_i(susp_n),
    .gint_n_i(gint_n), .sw_ovr_i(ovr), .led_blink_i(blink), .pwm_on_i(pwm),
    .host_xfer_i(xfer), .host_state_o(host_state), .evt_valid_o(evt_valid),
    .evt_ready_i(evt_ready), .evt_code_o(evt_code), .irq_o(irq), .kbd_en_o(kbd_en),
    .ptr_en_o(ptr_en), .level_o(level), .osc_en_o(osc_en), .clk_run_req_o(run_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] model_state(input logic p, input logic l, input logic s);
    if (!p) return 3'b000;
    if (!l) return 3'b011;
    if (!s) return 3'b010;
    return 3'b001;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: change lines, push the interrupts and alert this change must produce
  task automatic apply(input logic p, input logic l, input logic s, input logic [GINT_W-1:0] g);
    logic [2:0] ns;
    @(negedge clk);
    if (p != pg)    exp_irq_q.push_back(0);
    if (l != lid_n) exp_irq_q.push_back(1);
    for (int k = 0; k < GINT_W; k++)
      if (g[k] != gint_n[k]) exp_irq_q.push_back(2 + k);
    ns = model_state(p, l, s);
    if (ns != last_exp) begin
      exp_evt_q.push_back(ns);
      last_exp = ns;
    end
    pg = p; lid_n = l; susp_n = s; gint_n = g;
    wait_cyc(SETTLE);
  endtask

  // monitor: compare produced items with the expected queues
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (mon_on) begin
        if (evt_valid && evt_ready) begin
          if (exp_evt_q.size() == 0) check("R7 unexpected alert", evt_code, 7);
          else check("R7 alert code", evt_code, exp_evt_q.pop_front());
        end
        for (int b = 0; b < IRQ_W; b++) begin
          if (irq[b]) begin
            if (exp_irq_q.size() == 0) check("R6 unexpected irq bit", b, -1);
            else check("R6 irq bit", b, exp_irq_q.pop_front());
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    last_exp = 3'b000;
    wait_cyc(3);
    // R12 reset state
    check("R12 state", host_state, 0);
    check("R12 evt_valid", evt_valid, 0);
    check("R12 irq", irq, 0);
    check("R12 kbd_en", kbd_en, 0);
    check("R12 ptr_en", ptr_en, 0);
    check("R12 level", level, 0);
    // supply good rises from its reset value of low
    exp_irq_q.push_back(0);
    exp_evt_q.push_back(3'b001);
    last_exp = 3'b001;
    mon_on = 1'b1;
    rst_n = 1'b1;
    wait_cyc(SETTLE);
    check("R2 active", host_state, 1);
    check("R8 kbd active", kbd_en, 1);
    check("R8 ptr active", ptr_en, 1);
    check("R9 idle stop", level, 0);
    check("R9 osc off", osc_en, 0);

    apply(1, 1, 0, 2'b11);
    check("R3 host suspend", host_state, 2);
    check("R8 kbd susp", kbd_en, 1);
    check("R8 ptr susp", ptr_en, 0);
    apply(1, 0, 0, 2'b11);
    check("R4 lid closed", host_state, 3);
    check("R8 kbd lid", kbd_en, 0);
    apply(1, 0, 1, 2'b11);
    check("R4 lid ignores suspend", host_state, 3);
    apply(0, 0, 1, 2'b11);
    check("R1 critical", host_state, 0);
    apply(0, 1, 1, 2'b11);
    check("R1 lid ignored", host_state, 0);
    apply(1, 1, 1, 2'b11);
    check("R2 active again", host_state, 1);

    // R5 two-cycle glitch: no irq (monitor would flag), no level change
    @(negedge clk); gint_n[0] = 1'b0;
    wait_cyc(2); gint_n[0] = 1'b1;
    wait_cyc(SETTLE);
    check("R5 glitch level", level, 0);
    check("R5 glitch irq queue", exp_irq_q.size(), 0);

    apply(1, 1, 1, 2'b10);
    check("R11 gint held run", level, 2);
    check("R9 run req", run_req, 1);
    apply(1, 1, 1, 2'b11);
    check("R9 back to stop", level, 0);
    apply(1, 1, 1, 2'b01);
    apply(1, 1, 1, 2'b11);

    @(negedge clk); blink = 1'b1; wait_cyc(3);
    check("R10 blink wait", level, 1);
    check("R9 osc wait", osc_en, 1);
    check("R9 no run req", run_req, 0);
    @(negedge clk); blink = 1'b0; pwm = 2'b10; wait_cyc(3);
    check("R10 pwm wait", level, 1);
    @(negedge clk); xfer = 1'b1; wait_cyc(3);
    check("R11 xfer run", level, 2);
    @(negedge clk); xfer = 1'b0; pwm = '0; wait_cyc(3);
    check("R9 stop", level, 0);

    @(negedge clk); ovr = 3'b001; wait_cyc(2);
    check("R8 ovr kbd", kbd_en, 0);
    check("R8 ovr kbd ptr kept", ptr_en, 1);
    @(negedge clk); ovr = 3'b010; wait_cyc(2);
    check("R8 ovr ptr", ptr_en, 0);
    check("R8 ovr ptr kbd kept", kbd_en, 1);
    @(negedge clk); ovr = 3'b100; wait_cyc(3);
    check("R11 ovr run", level, 2);
    @(negedge clk); ovr = 3'b000; wait_cyc(3);

    // R7 back-pressure
    @(negedge clk); evt_ready = 1'b0;
    apply(1, 1, 0, 2'b11);
    check("R7 valid held", evt_valid, 1);
    check("R7 code held", evt_code, 2);
    check("R11 pending run", level, 2);
    apply(1, 0, 0, 2'b11);
    check("R7 code stable", evt_code, 2);
    @(negedge clk); evt_ready = 1'b1;
    wait_cyc(SETTLE);
    check("R7 drained", evt_valid, 0);
    apply(1, 1, 1, 2'b11);

    wait_cyc(SETTLE);
    check("R7 alert queue empty", exp_evt_q.size(), 0);
    check("R6 irq queue empty", exp_irq_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule